// File: doc/BRIEF.md
# Seek Difference Counter

This block keeps the distance that the head positioner still has to travel, together with a direction (reverse) flag, in a 10-bit register whose bits weigh 512 down to 1. For a seek, the controller loads the ones' complement of the seek length. Each track-crossing pulse from the servo then counts the register up by one, toward all-ones. A 150-cylinder seek therefore starts at 873 and reaches 1023 after 150 pulses. The same register can also hold an offset amount.

The lower eight bits are written in one command. The two upper bits and the reverse flag are written through a separate control command that carries a set of independent action bits. A permission check, built from the drive condition inputs, gates that control command. Two byte-wide readback buses always present the register: one holds the upper bits and the flag, the other the lower eight bits in reversed bit order. A terminal flag marks all-ones. A fine-enable flag marks one track to go while the servo also reports the half-track point. Downstream logic uses fine-enable to hand the positioner from coarse to fine control.

Top module: `seek_diff_counter`

## Requirements
- R1: After reset, both readback bytes are 0x00 and terminal and fineEnable are low.
- R2: When tagLoadLow and cmdValid are high together, the lower eight count bits are written from cmdBus, with bus bit 0 as weight 128 through bus bit 7 as weight 1. The upper bits and the reverse flag keep their values. Without cmdValid the write is ignored.
- R3: A tagCtrl command is accepted only when cmdValid is high, deviceCheck is low, (diag1 is low or diag2 is high), and (onCylinder is high or diag2 is high). Otherwise it changes nothing.
- R4: In an accepted tagCtrl command, bus bit 3 clears the count and the reverse flag. Bus bit 2 then writes weight 512 from bus bit 0 and weight 256 from bus bit 1. Without bit 2, bus bits 0 and 1 have no effect.
- R5: In an accepted tagCtrl command, bus bit 4 sets the reverse flag and bus bit 7 clears it. When both are present, set wins.
- R6: In an accepted tagCtrl command, bus bit 6 decrements the count by one, after any clear or upper-bit write in the same command. The count stays at 0 instead of wrapping.
- R7: A trackPulse increments the count by one. If a command is accepted in the same cycle (low write or control), the command is applied and the pulse is dropped.
- R8: terminal is high exactly when the count is 1023. A trackPulse at 1023 leaves the count at 1023.
- R9: fineEnable is high exactly when the count is 1022 and halfTrack is high.
- R10: statusHigh carries weight 512 on bit 0, weight 256 on bit 1 and the reverse flag on bit 4, with all other bits 0. It is driven whether or not a control command is accepted.
- R11: statusLow carries weight 128 on bit 0 through weight 1 on bit 7.
- R12: If tagLoadLow and tagCtrl are high in the same cycle with cmdValid, only the lower-byte write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdBus | input | 8 | Command data byte |
| cmdValid | input | 1 | Command data is valid |
| tagLoadLow | input | 1 | Lower-byte write strobe |
| tagCtrl | input | 1 | Control command strobe |
| deviceCheck | input | 1 | Drive error present |
| diag1 | input | 1 | First diagnostic mode active |
| diag2 | input | 1 | Second diagnostic mode active |
| onCylinder | input | 1 | Heads settled on a cylinder |
| trackPulse | input | 1 | One track crossed |
| halfTrack | input | 1 | Half-track point reached |
| statusHigh | output | 8 | Upper count bits and reverse flag |
| statusLow | output | 8 | Lower count bits, bit-reversed |
| terminal | output | 1 | Count is all-ones |
| fineEnable | output | 1 | One track to go at the half-track point |

## Verification
Two things can change the count in the same clock: a track-crossing pulse and an accepted command. In addition, the two command strobes can collide with each other. The stimulus table sets up these collisions directly. It raises trackPulse together with an accepted decrement, and then with a refused control command. It also raises both strobes with an all-ones byte, whose control actions would otherwise clear and rewrite the register. Each collision is judged by reading both readback bytes one cycle later. The expected value is the command result with the pulse lost, the pulse result when the command was refused, and the lower-byte write alone when both strobes collide.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // Bit positions of the actions carried by a control command
  localparam int CB_HI_A    = 0;
  localparam int CB_HI_B    = 1;
  localparam int CB_SET_HI  = 2;
  localparam int CB_CLEAR   = 3;
  localparam int CB_SET_REV = 4;
  localparam int CB_DECR    = 6;
  localparam int CB_CLR_REV = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLow;
    logic ctrlAct;
    logic clrCount;
    logic setHigh;
    logic decr;
    logic setRev;
    logic clrRev;
    logic step;
  } strobe_t;

endpackage

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
  import sdc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] cmdBus,
  input  logic              cmdValid,
  input  logic              tagLoadLow,
  input  logic              tagCtrl,
  input  logic              deviceCheck,
  input  logic              diag1,
  input  logic              diag2,
  input  logic              onCylinder,
  input  logic              trackPulse,
  input  logic              atTerminal,
  output strobe_t           stb
);

  logic permitted;
  logic lowAccept;
  logic ctrlAccept;

  always_comb begin
    permitted  = cmdValid && !deviceCheck && (!diag1 || diag2)
                 && (onCylinder || diag2);
    lowAccept  = tagLoadLow && cmdValid;
    ctrlAccept = tagCtrl && !lowAccept && permitted;
  end

  always_comb begin
    stb          = '0;
    stb.loadLow  = lowAccept;
    stb.ctrlAct  = ctrlAccept;
    stb.clrCount = ctrlAccept && cmdBus[CB_CLEAR];
    stb.setHigh  = ctrlAccept && cmdBus[CB_SET_HI];
    stb.decr     = ctrlAccept && cmdBus[CB_DECR];
    stb.setRev   = ctrlAccept && cmdBus[CB_SET_REV];
    stb.clrRev   = ctrlAccept && (cmdBus[CB_CLR_REV] || cmdBus[CB_CLEAR]);
    stb.step     = trackPulse && !lowAccept && !ctrlAccept && !atTerminal;
  end

endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] cmdBus,
  output logic [CNT_W-1:0]  count,
  output logic              reverse
);

  localparam int HIGH_W = CNT_W - BYTE_W;

  logic [BYTE_W-1:0] lowIn;
  logic [HIGH_W-1:0] highIn;
  logic [CNT_W-1:0]  ctrlNext;
  logic [CNT_W-1:0]  countNext;
  logic              revNext;

  // Bus bit 0 carries the heaviest weight of the lower byte
  for (genvar i = 0; i < BYTE_W; i++) begin : g_low
    assign lowIn[BYTE_W-1-i] = cmdBus[i];
  end

  // Bus bit 0 carries the heaviest upper bit
  for (genvar j = 0; j < HIGH_W; j++) begin : g_high
    assign highIn[HIGH_W-1-j] = cmdBus[j];
  end

  always_comb begin
    ctrlNext = count;
    if (stb.clrCount) ctrlNext = '0;
    if (stb.setHigh)  ctrlNext[CNT_W-1:BYTE_W] = highIn;
    if (stb.decr && (ctrlNext != '0)) ctrlNext = ctrlNext - 1'b1;
  end

  always_comb begin
    countNext = count;
    if (stb.loadLow)      countNext = {count[CNT_W-1:BYTE_W], lowIn};
    else if (stb.ctrlAct) countNext = ctrlNext;
    else if (stb.step)    countNext = count + 1'b1;
  end

  always_comb begin
    revNext = reverse;
    if (stb.clrRev) revNext = 1'b0;
    if (stb.setRev) revNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      reverse <= 1'b0;
    end else begin
      count   <= countNext;
      reverse <= revNext;
    end
  end

endmodule

// File: rtl/sdc_readback.sv
module sdc_readback #(
  parameter int CNT_W   = 10,
  parameter int BYTE_W  = 8,
  parameter int REV_POS = 4
) (
  input  logic [CNT_W-1:0]  count,
  input  logic              reverse,
  input  logic              halfTrack,
  output logic [BYTE_W-1:0] statusHigh,
  output logic [BYTE_W-1:0] statusLow,
  output logic              terminal,
  output logic              fineEnable
);

  localparam int HIGH_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE_TO_GO = ALL_ONES - 1'b1;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_low
    assign statusLow[i] = count[BYTE_W-1-i];
  end

  for (genvar k = 0; k < BYTE_W; k++) begin : g_high
    if (k < HIGH_W) begin : g_cnt
      assign statusHigh[k] = count[CNT_W-1-k];
    end else if (k == REV_POS) begin : g_rev
      assign statusHigh[k] = reverse;
    end else begin : g_zero
      assign statusHigh[k] = 1'b0;
    end
  end

  assign terminal   = (count == ALL_ONES);
  assign fineEnable = (count == ONE_TO_GO) && halfTrack;

endmodule

// File: rtl/seek_diff_counter.sv
module seek_diff_counter
  import sdc_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] cmdBus,
  input  logic              cmdValid,
  input  logic              tagLoadLow,
  input  logic              tagCtrl,
  input  logic              deviceCheck,
  input  logic              diag1,
  input  logic              diag2,
  input  logic              onCylinder,
  input  logic              trackPulse,
  input  logic              halfTrack,
  output logic [BYTE_W-1:0] statusHigh,
  output logic [BYTE_W-1:0] statusLow,
  output logic              terminal,
  output logic              fineEnable
);

  strobe_t          stb;
  logic [CNT_W-1:0] count;
  logic             reverse;

  sdc_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .cmdBus(cmdBus), .cmdValid(cmdValid), .tagLoadLow(tagLoadLow),
    .tagCtrl(tagCtrl), .deviceCheck(deviceCheck), .diag1(diag1),
    .diag2(diag2), .onCylinder(onCylinder), .trackPulse(trackPulse),
    .atTerminal(terminal), .stb(stb)
  );

  sdc_datapath #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdBus(cmdBus),
    .count(count), .reverse(reverse)
  );

  sdc_readback #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .REV_POS(CB_SET_REV)) rb_i (
    .count(count), .reverse(reverse), .halfTrack(halfTrack),
    .statusHigh(statusHigh), .statusLow(statusLow),
    .terminal(terminal), .fineEnable(fineEnable)
  );

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [BYTE_W-1:0] cmdBus,
  input logic              cmdValid,
  input logic              tagLoadLow,
  input logic              tagCtrl,
  input logic              deviceCheck,
  input logic              diag1,
  input logic              diag2,
  input logic              onCylinder,
  input logic              trackPulse,
  input logic              halfTrack,
  input logic [BYTE_W-1:0] statusHigh,
  input logic [BYTE_W-1:0] statusLow,
  input logic              terminal,
  input logic              fineEnable
);

  logic okCtrl;
  assign okCtrl = cmdValid && !deviceCheck && (!diag1 || diag2) && (onCylinder || diag2);

  // R2
  low_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tagLoadLow && cmdValid) |=> (statusLow == $past(cmdBus)));

  // R3
  refused_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tagCtrl && !okCtrl && !tagLoadLow && !trackPulse)
      |=> ($stable(statusLow) && $stable(statusHigh)));

  // R8
  saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (terminal && !tagLoadLow && !tagCtrl) |=> terminal);

  // R9
  fine_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    fineEnable |-> (halfTrack && !terminal));

  // R10
  high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusHigh & 8'hEC) == 8'h00);

  // R12
  collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tagLoadLow && tagCtrl && cmdValid) |=> $stable(statusHigh));

endmodule

bind seek_diff_counter sdc_checker #(.BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/seek_diff_counter_tb.sv
module seek_diff_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cmdBus = '0;
  logic       cmdValid = 0, tagLoadLow = 0, tagCtrl = 0, deviceCheck = 0;
  logic       diag1 = 0, diag2 = 0, onCylinder = 0, trackPulse = 0, halfTrack = 0;
  logic [7:0] statusHigh, statusLow;
  logic       terminal, fineEnable;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seek_diff_counter dut_i (.*);

  // ctl = {tagLoadLow, tagCtrl, cmdValid, deviceCheck, diag1, diag2,
  //        onCylinder, trackPulse, halfTrack}, bus, expHigh, expLow, {term, fine}
  localparam logic [34:0] VEC [0:NVEC-1] = '{
    {9'b101000100, 8'h96, 8'h00, 8'h96, 2'b00}, // R2 low byte 105
    {9'b011000100, 8'h07, 8'h03, 8'h96, 2'b00}, // R4 upper bits -> 873
    {9'b000000110, 8'h00, 8'h03, 8'h56, 2'b00}, // R7 pulse -> 874
    {9'b011100110, 8'h08, 8'h03, 8'hD6, 2'b00}, // R3 refused, R7 pulse -> 875
    {9'b011010100, 8'h08, 8'h03, 8'hD6, 2'b00}, // R3 diag1 blocks
    {9'b011011000, 8'h10, 8'h13, 8'hD6, 2'b00}, // R3 diag2 overrides, R5 set
    {9'b011000000, 8'h80, 8'h13, 8'hD6, 2'b00}, // R3 off cylinder blocks
    {9'b010000100, 8'h80, 8'h13, 8'hD6, 2'b00}, // R3 no cmdValid blocks
    {9'b011000100, 8'h80, 8'h03, 8'hD6, 2'b00}, // R5 clear reverse
    {9'b011000100, 8'h40, 8'h03, 8'h56, 2'b00}, // R6 decrement -> 874
    {9'b011000110, 8'h40, 8'h03, 8'h96, 2'b00}, // R7 command beats pulse -> 873
    {9'b011000100, 8'h03, 8'h03, 8'h96, 2'b00}, // R4 bits 0/1 without bit 2
    {9'b111000100, 8'hFF, 8'h03, 8'hFF, 2'b10}, // R12 both strobes -> 1023
    {9'b000000110, 8'h00, 8'h03, 8'hFF, 2'b10}, // R8 saturate
    {9'b011000100, 8'h40, 8'h03, 8'h7F, 2'b00}, // R6 -> 1022
    {9'b000000101, 8'h00, 8'h03, 8'h7F, 2'b01}, // R9 fine enable
    {9'b000000111, 8'h00, 8'h03, 8'hFF, 2'b10}, // R9 off at 1023, R8
    {9'b011000100, 8'h08, 8'h00, 8'h00, 2'b00}, // R4 clear
    {9'b011000100, 8'h40, 8'h00, 8'h00, 2'b00}, // R6 saturate at zero
    {9'b011000100, 8'h5D, 8'h12, 8'hFF, 2'b00}, // R4 R6 order -> 511, R5
    {9'b011000100, 8'h90, 8'h12, 8'hFF, 2'b00}  // R5 set wins
  };

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [8:0] ctl, logic [7:0] bus);
    {tagLoadLow, tagCtrl, cmdValid, deviceCheck, diag1, diag2,
     onCylinder, trackPulse, halfTrack} = ctl;
    cmdBus = bus;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk8("R1 statusHigh", statusHigh, 8'h00);
    chk8("R1 statusLow", statusLow, 8'h00);
    chk8("R1 flags", {6'd0, terminal, fineEnable}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][34:26], VEC[v][25:18]);
      @(negedge clk);
      chk8($sformatf("R10 statusHigh vec %0d", v), statusHigh, VEC[v][17:10]);
      chk8($sformatf("R11 statusLow vec %0d", v), statusLow, VEC[v][9:2]);
      chk8($sformatf("R8 R9 flags vec %0d", v), {6'd0, terminal, fineEnable},
           {6'd0, VEC[v][1:0]});
    end
    drive(9'd0, 8'h00);

    // R2 lower write ignored without cmdValid
    drive(9'b100000100, 8'hAA);
    @(negedge clk);
    chk8("R2 no valid", statusLow, 8'hFF);
    drive(9'd0, 8'h00);

    // R1 reset in mid operation
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk8("R1 rerun high", statusHigh, 8'h00);
    chk8("R1 rerun low", statusLow, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule